// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block is a register-mapped general-purpose I/O bank for up to 64 pins (36 by default, 30 in the smaller build). Software sets each pin's direction, drive level and drive style through a small synchronous register port. It reads the pin levels after a two-flop synchronizer. Each pin has an edge detector whose direction is chosen per pin. Detected edges latch into a sticky status vector that software clears by writing ones. The status vector feeds a single combined interrupt line, gated by a per-pin enable mask, and a wake request line, gated by a separate per-pin wake mask.

Two address spaces are chosen by a space-select input: the pin space and the interrupt space. Every function takes two 32-bit words. Pin n below 32 sits in bit n of the base word. Pin n of 32 or more sits in bit n-32 of the word 4 bytes above the base. Register reads are combinational from the current address. Writes take effect at the rising clock edge.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads zero, and `pinOut`, `pinOe`, `irq` and `wake` are all low.
- R2: In the pin space (`regSpace`=0), the direction word is at 0x00 and 0x04, and a 1 makes that pin an output. The drive-level word is at 0x18 and 0x1C. Pin n of 32 or more is bit n-32 of the +4 word, and `pinOut` follows the drive-level bits.
- R3: The drive-style word at 0x20 and 0x24 selects open-drain per pin. When a pin's bit is 1, `pinOe` for that pin is high only while its direction bit is 1 and its drive level is 0.
- R4: The input word at 0x10 and 0x14 returns the pin levels after two clock edges of synchronization. Writes to it have no effect.
- R5: In the interrupt space (`regSpace`=1), the polarity word is at 0x08 and 0x0C. A bit of 0 detects a rising edge and a 1 detects a falling edge. An edge on a pin changed before rising edge k sets that pin's status bit (0x10 and 0x14) at edge k+2.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clearing write, the bit stays set.
- R7: `irq` is high exactly when some status bit is set and its enable bit (0x00 and 0x04 in the interrupt space) is also set.
- R8: `wake` is high exactly when some status bit is set and its wake bit (0x18 and 0x1C) is set, whatever its enable bit is.
- R9: Bits for pins at or above the pin count read as zero and cannot be written. Addresses with no register read as zero.
- R10: Status bits latch whether or not the pin is enabled, so enabling a pin later raises `irq` for an edge that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSpace | input | 1 | 0 selects the pin space, 1 selects the interrupt space |
| regAddr | input | 6 | Byte address of the register word |
| regWe | input | 1 | Write strobe, taken at the rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current address |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Pin drive levels |
| pinOe | output | PIN_COUNT | Pin output enables |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake request |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a new edge on the same pin. Only that timing shows whether set or clear takes priority. The stimulus first leaves the bit set, returns the pin to idle, and then toggles it. It places the write-one strobe so that the register samples it on the third rising edge after the toggle, which is the edge where the synchronized transition is detected. A behavioural model, advanced on every clock, also checks randomized writes and pin activity in both word halves.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int PAD_W  = 2 * DATA_W;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OE, SEL_IN, SEL_OUT, SEL_OD,
    SEL_IEN, SEL_POL, SEL_STS, SEL_WAKE
  } rd_sel_e;

  typedef struct packed {
    logic    wrOe;
    logic    wrOut;
    logic    wrOd;
    logic    wrIen;
    logic    wrPol;
    logic    wrClr;
    logic    wrWake;
    logic    hiWord;
    rd_sel_e rdSel;
  } bank_strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              regSpace,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output bank_strobe_t      stb
);
  logic [3:0] slot;
  assign slot = {regSpace, regAddr[5:3]};

  always_comb begin
    stb        = '0;
    stb.hiWord = regAddr[2];
    stb.rdSel  = SEL_NONE;
    if (regAddr[1:0] == 2'b00) begin
      case (slot)
        4'b0000: begin stb.rdSel = SEL_OE;   stb.wrOe   = regWe; end
        4'b0010: begin stb.rdSel = SEL_IN;                        end
        4'b0011: begin stb.rdSel = SEL_OUT;  stb.wrOut  = regWe; end
        4'b0100: begin stb.rdSel = SEL_OD;   stb.wrOd   = regWe; end
        4'b1000: begin stb.rdSel = SEL_IEN;  stb.wrIen  = regWe; end
        4'b1001: begin stb.rdSel = SEL_POL;  stb.wrPol  = regWe; end
        4'b1010: begin stb.rdSel = SEL_STS;  stb.wrClr  = regWe; end
        4'b1011: begin stb.rdSel = SEL_WAKE; stb.wrWake = regWe; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bank_strobe_t         stb,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq,
  output logic                 wake,
  output logic [PIN_COUNT-1:0] stsState,
  output logic [PIN_COUNT-1:0] ienState
);
  logic [PIN_COUNT-1:0] oeReg, outReg, odReg, ienReg, polReg, stsReg, wkReg;
  logic [PIN_COUNT-1:0] syncA, syncB, prevLvl;
  logic [PIN_COUNT-1:0] wrData, wrMask, edgeHit;

  // Per-pin word steering and edge detection
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    if (i < DATA_W) begin : g_lo
      assign wrData[i] = !stb.hiWord && wdata[i];
      assign wrMask[i] = !stb.hiWord;
    end else begin : g_hi
      assign wrData[i] = stb.hiWord && wdata[i-DATA_W];
      assign wrMask[i] = stb.hiWord;
    end
    assign edgeHit[i] = polReg[i] ? (prevLvl[i] && !syncB[i])
                                  : (!prevLvl[i] && syncB[i]);
  end

  function automatic logic [PIN_COUNT-1:0] mergeBits(
    input logic [PIN_COUNT-1:0] cur, input logic [PIN_COUNT-1:0] dat,
    input logic [PIN_COUNT-1:0] msk);
    return (cur & ~msk) | (dat & msk);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeReg   <= '0;
      outReg  <= '0;
      odReg   <= '0;
      ienReg  <= '0;
      polReg  <= '0;
      stsReg  <= '0;
      wkReg   <= '0;
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
      if (stb.wrOe)   oeReg  <= mergeBits(oeReg,  wrData, wrMask);
      if (stb.wrOut)  outReg <= mergeBits(outReg, wrData, wrMask);
      if (stb.wrOd)   odReg  <= mergeBits(odReg,  wrData, wrMask);
      if (stb.wrIen)  ienReg <= mergeBits(ienReg, wrData, wrMask);
      if (stb.wrPol)  polReg <= mergeBits(polReg, wrData, wrMask);
      if (stb.wrWake) wkReg  <= mergeBits(wkReg,  wrData, wrMask);
      // new edges win over a same-cycle clear
      stsReg <= (stsReg & ~(stb.wrClr ? (wrData & wrMask) : '0)) | edgeHit;
    end
  end

  logic [PIN_COUNT-1:0] rdVec;
  logic [PAD_W-1:0]     rdPad;

  always_comb begin
    case (stb.rdSel)
      SEL_OE:   rdVec = oeReg;
      SEL_IN:   rdVec = syncB;
      SEL_OUT:  rdVec = outReg;
      SEL_OD:   rdVec = odReg;
      SEL_IEN:  rdVec = ienReg;
      SEL_POL:  rdVec = polReg;
      SEL_STS:  rdVec = stsReg;
      SEL_WAKE: rdVec = wkReg;
      default:  rdVec = '0;
    endcase
    rdPad                  = '0;
    rdPad[PIN_COUNT-1:0]   = rdVec;
    rdata = stb.hiWord ? rdPad[PAD_W-1:DATA_W] : rdPad[DATA_W-1:0];
  end

  assign pinOut   = outReg;
  assign pinOe    = oeReg & ~(odReg & outReg);
  assign irq      = |(stsReg & ienReg);
  assign wake     = |(stsReg & wkReg);
  assign stsState = stsReg;
  assign ienState = ienReg;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSpace,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irq,
  output logic                 wake
);
  bank_strobe_t         stb;
  logic [PIN_COUNT-1:0] stsState, ienState;

  gpio_bank_ctrl u_ctrl (
    .regSpace (regSpace),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .stb      (stb)
  );

  gpio_bank_dpath #(.PIN_COUNT(PIN_COUNT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (regWdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdata    (regRdata),
    .irq      (irq),
    .wake     (wake),
    .stsState (stsState),
    .ienState (ienState)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 36
) (
  input logic                 clk,
  input logic                 rstN,
  input bank_strobe_t         stb,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regRdata,
  input logic                 irq,
  input logic                 wake,
  input logic [PIN_COUNT-1:0] stsState,
  input logic [PIN_COUNT-1:0] ienState
);
  function automatic logic [DATA_W-1:0] hiMask();
    logic [DATA_W-1:0] m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i + DATA_W < PIN_COUNT) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] HI_MASK = hiMask();

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!irq && !wake));

  p_clear_needs_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|stsState) |-> $past(stb.wrClr));

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|ienState));

  p_wake_needs_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> (|stsState));

  p_upper_bits_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    regAddr[2] |-> ((regRdata & ~HI_MASK) == '0));
endmodule

bind gpio_bank gpio_bank_checker #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stb      (stb),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .irq      (irq),
  .wake     (wake),
  .stsState (stsState),
  .ienState (ienState)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int PINS = 36;
  localparam logic [63:0] VALID = (64'd1 << PINS) - 64'd1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regSpace = 1'b0;
  logic [5:0]      regAddr = '0;
  logic            regWe = 1'b0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOe;
  logic            irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_bank #(.PIN_COUNT(PINS)) u_dut (
    .clk(clk), .rstN(rstN), .regSpace(regSpace), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq), .wake(wake)
  );

  // Behavioural reference model
  logic [63:0] mOe, mOut, mOd, mIen, mPol, mSts, mWk;
  logic [63:0] mLvlQ [$];

  function automatic logic [63:0] wideOf(input logic hi, input logic [31:0] d);
    return (hi ? {d, 32'h0} : {32'h0, d}) & VALID;
  endfunction
  function automatic logic [63:0] maskOf(input logic hi);
    return (hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF}) & VALID;
  endfunction

  function automatic logic [31:0] modelRead(input logic sp, input logic [5:0] a);
    logic [63:0] v;
    v = '0;
    if (a[1:0] == 2'b00) begin
      if (!sp) begin
        case (a[5:3])
          3'd0: v = mOe;
          3'd2: v = (mLvlQ.size() > 1) ? mLvlQ[1] : 64'h0;
          3'd3: v = mOut;
          3'd4: v = mOd;
          default: v = '0;
        endcase
      end else begin
        case (a[5:3])
          3'd0: v = mIen;
          3'd1: v = mPol;
          3'd2: v = mSts;
          3'd3: v = mWk;
          default: v = '0;
        endcase
      end
    end
    return a[2] ? v[63:32] : v[31:0];
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic [63:0] s2, pv, ev, dat, msk, clr;
    if (!rstN) begin
      mOe = '0; mOut = '0; mOd = '0; mIen = '0; mPol = '0; mSts = '0; mWk = '0;
      mLvlQ = '{64'h0, 64'h0, 64'h0};
    end else begin
      // queue holds [stage1, stage2, previous]
      s2  = mLvlQ[1];
      pv  = mLvlQ[2];
      ev  = ((s2 & ~pv & ~mPol) | (~s2 & pv & mPol)) & VALID;
      dat = wideOf(regAddr[2], regWdata);
      msk = maskOf(regAddr[2]);
      clr = '0;
      if (regWe && regAddr[1:0] == 2'b00) begin
        if (!regSpace) begin
          case (regAddr[5:3])
            3'd0: mOe  = (mOe  & ~msk) | (dat & msk);
            3'd3: mOut = (mOut & ~msk) | (dat & msk);
            3'd4: mOd  = (mOd  & ~msk) | (dat & msk);
            default: ;
          endcase
        end else begin
          case (regAddr[5:3])
            3'd0: mIen = (mIen & ~msk) | (dat & msk);
            3'd1: mPol = (mPol & ~msk) | (dat & msk);
            3'd2: clr  = dat;
            3'd3: mWk  = (mWk  & ~msk) | (dat & msk);
            default: ;
          endcase
        end
      end
      mSts = (mSts & ~clr) | ev;
      void'(mLvlQ.pop_back());
      mLvlQ.push_front({28'h0, pinIn} & VALID);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    logic [63:0] eOe;
    #2;
    if (!done && rstN) begin
      eOe = mOe & ~(mOd & mOut);
      check(pinOut == mOut[PINS-1:0], "R2 pinOut", 64'(pinOut), mOut);
      check(pinOe == eOe[PINS-1:0], "R3 pinOe", 64'(pinOe), eOe);
      check(irq == |(mSts & mIen), "R7 irq", 64'(irq), 64'(|(mSts & mIen)));
      check(wake == |(mSts & mWk), "R8 wake", 64'(wake), 64'(|(mSts & mWk)));
      check(regRdata == modelRead(regSpace, regAddr), "R9 readback",
            64'(regRdata), 64'(modelRead(regSpace, regAddr)));
    end
  end

  task automatic wr(input logic sp, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regSpace = sp; regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic sp, input logic [5:0] a, input logic [31:0] exp,
                    input string tag);
    @(negedge clk);
    regSpace = sp; regAddr = a; regWe = 1'b0;
    #1;
    check(regRdata == exp, tag, 64'(regRdata), 64'(exp));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    for (int a = 0; a < 10; a++) begin
      rd(1'b0, 6'(a * 4), 32'h0, "R1 pin space reset");
      rd(1'b1, 6'(a * 4), 32'h0, "R1 irq space reset");
    end
    check(pinOe == '0 && pinOut == '0 && !irq && !wake, "R1 outputs",
          64'({pinOe, pinOut, irq, wake}), 64'h0);

    // R2: direction and drive words, upper pins in +4 word
    wr(1'b0, 6'h00, 32'h0000_00F0);
    wr(1'b0, 6'h04, 32'h0000_000F);
    wr(1'b0, 6'h18, 32'h0000_0030);
    rd(1'b0, 6'h04, 32'h0000_000F, "R2 direction hi word");
    check(pinOe[35:32] == 4'hF && pinOe[7:4] == 4'hF, "R2 pinOe bits",
          64'(pinOe), 64'h0000_000F_0000_00F0);
    // R9: pins above the count are not stored
    wr(1'b0, 6'h04, 32'hFFFF_FFFF);
    rd(1'b0, 6'h04, 32'h0000_000F, "R9 upper bits read zero");
    rd(1'b0, 6'h28, 32'h0, "R9 unmapped address");
    // R3: open-drain on pin 4 (level 1) releases the pin, pin 5 unaffected
    wr(1'b0, 6'h20, 32'h0000_0010);
    #1;
    check(pinOe[4] == 1'b0 && pinOe[5] == 1'b1, "R3 open drain",
          64'(pinOe[5:4]), 64'h2);

    // R4: two-edge synchronizer on the input word
    @(negedge clk);
    regSpace = 1'b0; regAddr = 6'h10;
    pinIn[3] = 1'b1;
    @(negedge clk); #1;
    check(regRdata == 32'h0, "R4 sync stage one", 64'(regRdata), 64'h0);
    @(negedge clk); #1;
    check(regRdata == 32'h8, "R4 sync stage two", 64'(regRdata), 64'h8);
    wr(1'b0, 6'h10, 32'h0);
    rd(1'b0, 6'h10, 32'h8, "R4 input word write ignored");

    // clear all pending status
    repeat (4) @(negedge clk);
    wr(1'b1, 6'h10, 32'hFFFF_FFFF);
    wr(1'b1, 6'h14, 32'hFFFF_FFFF);
    rd(1'b1, 6'h10, 32'h0, "R6 clear all lo");

    // R5: falling polarity on pin 33
    wr(1'b1, 6'h0C, 32'h2);
    @(negedge clk);
    pinIn[33] = 1'b1;
    repeat (5) @(negedge clk);
    rd(1'b1, 6'h14, 32'h0, "R5 rising ignored when falling selected");
    pinIn[33] = 1'b0;
    @(negedge clk); #1;
    check(regRdata == 32'h0, "R5 status after 1 edge", 64'(regRdata), 64'h0);
    @(negedge clk); #1;
    check(regRdata == 32'h0, "R5 status after 2 edges", 64'(regRdata), 64'h0);
    @(negedge clk); #1;
    check(regRdata == 32'h2, "R5 status after 3 edges", 64'(regRdata), 64'h2);

    // R10 / R7: pending but disabled, then enabled
    check(irq == 1'b0, "R10 disabled pending keeps irq low", 64'(irq), 64'h0);
    wr(1'b1, 6'h04, 32'h2);
    #1;
    check(irq == 1'b1, "R10 enabling exposes pending edge", 64'(irq), 64'h1);

    // R8: wake on pin 0 without enable
    wr(1'b1, 6'h18, 32'h1);
    @(negedge clk);
    pinIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    check(wake == 1'b1, "R8 wake without enable", 64'(wake), 64'h1);

    // R6: write zero no effect, write one clears
    wr(1'b1, 6'h14, 32'h0);
    rd(1'b1, 6'h14, 32'h2, "R6 write zero keeps bit");
    wr(1'b1, 6'h14, 32'h2);
    rd(1'b1, 6'h14, 32'h0, "R6 write one clears");
    #1;
    check(irq == 1'b0, "R7 irq drops after clear", 64'(irq), 64'h0);

    // R6: edge and clear in the same cycle on pin 0 (status bit already set)
    pinIn[0] = 1'b0;
    repeat (5) @(negedge clk);
    pinIn[0] = 1'b1;
    @(negedge clk);
    wr(1'b1, 6'h10, 32'h1);
    rd(1'b1, 6'h10, 32'h1, "R6 same-cycle edge survives clear");
    wr(1'b1, 6'h10, 32'h1);
    rd(1'b1, 6'h10, 32'h0, "R6 later clear works");
    #1;
    check(wake == 1'b0, "R8 wake drops after clear", 64'(wake), 64'h0);

    // Randomized traffic checked by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pinIn = {$urandom(), $urandom()} & VALID[PINS-1:0];
      regSpace = 1'($urandom_range(0, 1));
      regAddr  = 6'($urandom_range(0, 10) * 4);
      regWdata = $urandom();
      regWe    = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    regWe = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule